// File: doc/BRIEF.md
# MAC Operand Address Generator

This block supplies the two memory operand addresses for a multiply-accumulate instruction that uses double indirect addressing. The first operand comes through one of two index pointers. The second comes through one of sixteen general word pointers. On each instruction issue, the block presents both addresses as they were before the instruction touched them. On the following clock edge, it post-modifies the two pointers that were used.

Each pointer family has two offset registers of its own. The five modification modes are: hold, step up by 2, step down by 2, add the chosen offset, and subtract the chosen offset. For the move-capable instruction class in double indirect mode, the block also produces a write-back address for a parallel data move. This address applies the opposite of the index pointer's modification to the pointer value before modification. A move request whose index mode does not modify the pointer is flagged as illegal, and no write-back address is given for it.

Offset registers are loaded through a dedicated write port. The pointers can only be reached through their post-modification.

Top module: `mac_opaddr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears every index pointer, every general pointer and all four offset registers to zero.
- R2: While `issue_i` is high, `idx_addr_o` equals the selected index pointer and `gpr_addr_o` equals the selected general pointer, both taken before modification and both with bit 0 cleared.
- R3: The mode codes are the same on `idx_mode_i` and `gpr_mode_i`: 0 hold, 1 add 2, 2 subtract 2, 3 add the chosen offset, 4 subtract the chosen offset, and 5 to 7 hold. Only the selected pointer of each family changes, at the clock edge that ends the issue cycle.
- R4: `idx_ofs_sel_i` picks index-family offset 0 or 1. `gpr_ofs_sel_i` picks general-family offset 0 or 1.
- R5: All pointer and address arithmetic is modulo 2^16 and wraps silently.
- R6: Pointers change only at the edge that ends an issue cycle. An offset write never changes a pointer.
- R7: When `ofs_we_i` is high, offset register `ofs_idx_i` of the family given by `ofs_bank_i` (0 index family, 1 general family) takes `ofs_wdata_i` at the clock edge. An instruction issued in that same cycle still uses the old value.
- R8: `wb_valid_o` is high only when `issue_i`, `move_cls_i` and `dbl_ind_i` are all high and the index mode is 1 to 4. It is low in every other case.
- R9: When the write-back is valid, `wb_addr_o` is the index pointer before modification with the inverse step applied (mode 1 gives minus 2, mode 2 plus 2, mode 3 minus the offset, mode 4 plus the offset), with bit 0 cleared.
- R10: `illegal_o` is high exactly when `issue_i`, `move_cls_i` and `dbl_ind_i` are high and the index mode is 0 or 5 to 7. It is never high together with `wb_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Instruction issue strobe |
| move_cls_i | input | 1 | Instruction belongs to the move-capable class |
| dbl_ind_i | input | 1 | Double indirect addressing in use |
| idx_sel_i | input | 1 | Index pointer select |
| idx_mode_i | input | 3 | Index pointer modification mode |
| idx_ofs_sel_i | input | 1 | Index-family offset select |
| gpr_sel_i | input | 4 | General pointer select |
| gpr_mode_i | input | 3 | General pointer modification mode |
| gpr_ofs_sel_i | input | 1 | General-family offset select |
| ofs_we_i | input | 1 | Offset register write enable |
| ofs_bank_i | input | 1 | Offset family for the write (0 index, 1 general) |
| ofs_idx_i | input | 1 | Offset register number within the family |
| ofs_wdata_i | input | 16 | Offset write data |
| idx_addr_o | output | 16 | Index operand address |
| gpr_addr_o | output | 16 | General operand address |
| wb_addr_o | output | 16 | Parallel-move write-back address |
| wb_valid_o | output | 1 | Write-back address is valid |
| illegal_o | output | 1 | Move requested with a non-modifying index mode |
| idx_ptr_o | output | 32 | All index pointers, pointer k at bits [16k+15:16k] |
| gpr_ptr_o | output | 256 | All general pointers, pointer k at bits [16k+15:16k] |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, two index pointers, sixteen general pointers and two offsets per family. With 16-bit width, a single step down from the reset value already exercises wrap-around. Odd offset values expose the bit-0 masking of the addresses. With two offsets per family, random select bits reach every register, and random traffic spreads modifications across all sixteen general pointers. An offset write in the same cycle as an issue, and move requests with each non-modifying index code, are added as directed cases.

// File: rtl/mac_agu_pkg.sv
package mac_agu_pkg;

    // Pointer post-modification codes shared by both pointer families
    typedef enum logic [2:0] {
        PM_HOLD = 3'd0,
        PM_INC  = 3'd1,
        PM_DEC  = 3'd2,
        PM_ADDQ = 3'd3,
        PM_SUBQ = 3'd4
    } pmode_e;

    // Decoded parallel-move status for one issue cycle
    typedef struct packed {
        logic mv_req;
        logic wb_vld;
        logic bad_mode;
    } mv_dec_t;

    // True when the code actually modifies the pointer
    function automatic logic pm_modifies(input logic [2:0] m);
        return (m == PM_INC) || (m == PM_DEC) || (m == PM_ADDQ) || (m == PM_SUBQ);
    endfunction

endpackage

// File: rtl/mac_ptr_step.sv
module mac_ptr_step
    import mac_agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base_i,
    input  logic [2:0]    mode_i,
    input  logic [AW-1:0] ofs_i,
    output logic [AW-1:0] next_o,
    output logic [AW-1:0] inv_o
);

    localparam logic [AW-1:0] STEP = AW'(2);

    // Forward step for the pointer and its inverse for the write-back
    always_comb begin
        next_o = base_i;
        inv_o  = base_i;
        case (mode_i)
            PM_INC: begin
                next_o = base_i + STEP;
                inv_o  = base_i - STEP;
            end
            PM_DEC: begin
                next_o = base_i - STEP;
                inv_o  = base_i + STEP;
            end
            PM_ADDQ: begin
                next_o = base_i + ofs_i;
                inv_o  = base_i - ofs_i;
            end
            PM_SUBQ: begin
                next_o = base_i - ofs_i;
                inv_o  = base_i + ofs_i;
            end
            default: begin
                next_o = base_i;
                inv_o  = base_i;
            end
        endcase
    end

endmodule

// File: rtl/mac_reg_bank.sv
module mac_reg_bank #(
    parameter int AW = 16,
    parameter int N  = 2,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we_i,
    input  logic [SW-1:0]   wsel_i,
    input  logic [AW-1:0]   wdata_i,
    input  logic [SW-1:0]   rsel_i,
    output logic [AW-1:0]   rdata_o,
    output logic [N*AW-1:0] all_o
);

    // One register per entry, each with its own next-value process
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [AW-1:0] val_d;
        logic [AW-1:0] val_q;

        always_comb begin
            val_d = val_q;
            if (we_i && (wsel_i == SW'(g))) begin
                val_d = wdata_i;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else begin
                val_q <= val_d;
            end
        end

        assign all_o[g*AW +: AW] = val_q;
    end

    assign rdata_o = all_o[int'(rsel_i)*AW +: AW];

endmodule

// File: rtl/mac_opaddr_gen.sv
module mac_opaddr_gen
    import mac_agu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NIDX = 2,
    parameter int NGPR = 16,
    parameter int NOFS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      issue_i,
    input  logic                      move_cls_i,
    input  logic                      dbl_ind_i,
    input  logic [$clog2(NIDX)-1:0]   idx_sel_i,
    input  logic [2:0]                idx_mode_i,
    input  logic [$clog2(NOFS)-1:0]   idx_ofs_sel_i,
    input  logic [$clog2(NGPR)-1:0]   gpr_sel_i,
    input  logic [2:0]                gpr_mode_i,
    input  logic [$clog2(NOFS)-1:0]   gpr_ofs_sel_i,
    input  logic                      ofs_we_i,
    input  logic                      ofs_bank_i,
    input  logic [$clog2(NOFS)-1:0]   ofs_idx_i,
    input  logic [AW-1:0]             ofs_wdata_i,
    output logic [AW-1:0]             idx_addr_o,
    output logic [AW-1:0]             gpr_addr_o,
    output logic [AW-1:0]             wb_addr_o,
    output logic                      wb_valid_o,
    output logic                      illegal_o,
    output logic [NIDX*AW-1:0]        idx_ptr_o,
    output logic [NGPR*AW-1:0]        gpr_ptr_o
);

    localparam logic [AW-1:0] ALIGN_MASK = {{(AW-1){1'b1}}, 1'b0};

    logic [AW-1:0] idx_base;
    logic [AW-1:0] gpr_base;
    logic [AW-1:0] qx_val;
    logic [AW-1:0] qr_val;
    logic [AW-1:0] idx_next;
    logic [AW-1:0] idx_inv;
    logic [AW-1:0] gpr_next;
    logic [AW-1:0] gpr_inv_unused_sink;
    logic [NOFS*AW-1:0] qx_all;
    logic [NOFS*AW-1:0] qr_all;
    mv_dec_t mv;

    // Offset registers, one bank per pointer family
    mac_reg_bank #(.AW(AW), .N(NOFS)) u_qx (
        .clk     (clk),
        .rst     (rst),
        .we_i    (ofs_we_i && !ofs_bank_i),
        .wsel_i  (ofs_idx_i),
        .wdata_i (ofs_wdata_i),
        .rsel_i  (idx_ofs_sel_i),
        .rdata_o (qx_val),
        .all_o   (qx_all)
    );

    mac_reg_bank #(.AW(AW), .N(NOFS)) u_qr (
        .clk     (clk),
        .rst     (rst),
        .we_i    (ofs_we_i && ofs_bank_i),
        .wsel_i  (ofs_idx_i),
        .wdata_i (ofs_wdata_i),
        .rsel_i  (gpr_ofs_sel_i),
        .rdata_o (qr_val),
        .all_o   (qr_all)
    );

    // Pointer registers, updated on every issue with the stepped value
    mac_reg_bank #(.AW(AW), .N(NIDX)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .we_i    (issue_i),
        .wsel_i  (idx_sel_i),
        .wdata_i (idx_next),
        .rsel_i  (idx_sel_i),
        .rdata_o (idx_base),
        .all_o   (idx_ptr_o)
    );

    mac_reg_bank #(.AW(AW), .N(NGPR)) u_gpr (
        .clk     (clk),
        .rst     (rst),
        .we_i    (issue_i),
        .wsel_i  (gpr_sel_i),
        .wdata_i (gpr_next),
        .rsel_i  (gpr_sel_i),
        .rdata_o (gpr_base),
        .all_o   (gpr_ptr_o)
    );

    // Step units
    mac_ptr_step #(.AW(AW)) u_idx_step (
        .base_i (idx_base),
        .mode_i (idx_mode_i),
        .ofs_i  (qx_val),
        .next_o (idx_next),
        .inv_o  (idx_inv)
    );

    mac_ptr_step #(.AW(AW)) u_gpr_step (
        .base_i (gpr_base),
        .mode_i (gpr_mode_i),
        .ofs_i  (qr_val),
        .next_o (gpr_next),
        .inv_o  (gpr_inv_unused_sink)
    );

    // Parallel-move decode
    always_comb begin
        mv.mv_req   = issue_i && move_cls_i && dbl_ind_i;
        mv.wb_vld   = mv.mv_req && pm_modifies(idx_mode_i);
        mv.bad_mode = mv.mv_req && !pm_modifies(idx_mode_i);
    end

    assign idx_addr_o = idx_base & ALIGN_MASK;
    assign gpr_addr_o = gpr_base & ALIGN_MASK;
    assign wb_addr_o  = idx_inv & ALIGN_MASK;
    assign wb_valid_o = mv.wb_vld;
    assign illegal_o  = mv.bad_mode;

    // Full offset banks and the general inverse are not needed at the edge
    logic unused_ok;
    assign unused_ok = ^{qx_all, qr_all, gpr_inv_unused_sink};

endmodule

// File: rtl/mac_agu_chk.sv
module mac_agu_chk #(
    parameter int AW   = 16,
    parameter int NIDX = 2,
    parameter int NGPR = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    issue_i,
    input logic                    move_cls_i,
    input logic                    dbl_ind_i,
    input logic [$clog2(NIDX)-1:0] idx_sel_i,
    input logic [2:0]              idx_mode_i,
    input logic [$clog2(NGPR)-1:0] gpr_sel_i,
    input logic [2:0]              gpr_mode_i,
    input logic [AW-1:0]           idx_addr_o,
    input logic [AW-1:0]           gpr_addr_o,
    input logic [AW-1:0]           wb_addr_o,
    input logic                    wb_valid_o,
    input logic                    illegal_o,
    input logic [NIDX*AW-1:0]      idx_ptr_o,
    input logic [NGPR*AW-1:0]      gpr_ptr_o
);

    logic [AW-1:0] idx_cur;
    logic [AW-1:0] gpr_cur;
    assign idx_cur = idx_ptr_o[int'(idx_sel_i)*AW +: AW];
    assign gpr_cur = gpr_ptr_o[int'(gpr_sel_i)*AW +: AW];

    assert_addr_align_R2: assert property (@(posedge clk) disable iff (rst)
        issue_i |-> (idx_addr_o[0] == 1'b0) && (gpr_addr_o[0] == 1'b0) && (wb_addr_o[0] == 1'b0));

    assert_idx_inc_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_i && idx_mode_i == 3'd1) |=>
            idx_ptr_o[int'($past(idx_sel_i))*AW +: AW] == AW'($past(idx_cur) + AW'(2)));

    assert_gpr_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_i && gpr_mode_i == 3'd2) |=>
            gpr_ptr_o[int'($past(gpr_sel_i))*AW +: AW] == AW'($past(gpr_cur) - AW'(2)));

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> $stable(idx_ptr_o) && $stable(gpr_ptr_o));

    assert_wb_gate_R8: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> issue_i && move_cls_i && dbl_ind_i);

    assert_wb_inv_inc_R9: assert property (@(posedge clk) disable iff (rst)
        (wb_valid_o && idx_mode_i == 3'd1) |-> wb_addr_o == AW'(idx_addr_o - AW'(2)));

    assert_wb_inv_dec_R9: assert property (@(posedge clk) disable iff (rst)
        (wb_valid_o && idx_mode_i == 3'd2) |-> wb_addr_o == AW'(idx_addr_o + AW'(2)));

    assert_mv_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_valid_o, illegal_o}));

    assert_mv_cover_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_i && move_cls_i && dbl_ind_i) |-> (wb_valid_o || illegal_o));

endmodule

bind mac_opaddr_gen mac_agu_chk #(.AW(AW), .NIDX(NIDX), .NGPR(NGPR)) u_chk (.*);

// File: tb/sim_mac_opaddr_gen.sv
module sim_mac_opaddr_gen;

    localparam int AW   = 16;
    localparam int NIDX = 2;
    localparam int NGPR = 16;
    localparam int NOFS = 2;

    // 20 time units per period: 50 MHz at 1 ns
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst;
    logic               issue_i, move_cls_i, dbl_ind_i;
    logic [0:0]         idx_sel_i, idx_ofs_sel_i, gpr_ofs_sel_i, ofs_idx_i;
    logic [2:0]         idx_mode_i, gpr_mode_i;
    logic [3:0]         gpr_sel_i;
    logic               ofs_we_i, ofs_bank_i;
    logic [AW-1:0]      ofs_wdata_i;
    logic [AW-1:0]      idx_addr_o, gpr_addr_o, wb_addr_o;
    logic               wb_valid_o, illegal_o;
    logic [NIDX*AW-1:0] idx_ptr_o;
    logic [NGPR*AW-1:0] gpr_ptr_o;

    mac_opaddr_gen #(.AW(AW), .NIDX(NIDX), .NGPR(NGPR), .NOFS(NOFS)) u0 (.*);

    int n_run  = 0;
    int n_fail = 0;

    logic [AW-1:0] m_idx [NIDX];
    logic [AW-1:0] m_gpr [NGPR];
    logic [AW-1:0] m_qx  [NOFS];
    logic [AW-1:0] m_qr  [NOFS];

    function automatic logic [15:0] f_next(input logic [15:0] b, input logic [2:0] m, input logic [15:0] q);
        case (m)
            3'd1:    return b + 16'd2;
            3'd2:    return b - 16'd2;
            3'd3:    return b + q;
            3'd4:    return b - q;
            default: return b;
        endcase
    endfunction

    function automatic logic [15:0] f_wb(input logic [15:0] b, input logic [2:0] m, input logic [15:0] q);
        case (m)
            3'd1:    return (b - 16'd2) & 16'hFFFE;
            3'd2:    return (b + 16'd2) & 16'hFFFE;
            3'd3:    return (b - q) & 16'hFFFE;
            3'd4:    return (b + q) & 16'hFFFE;
            default: return 16'h0;
        endcase
    endfunction

    function automatic bit f_moves(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NIDX; k++) m_idx[k] = '0;
        for (int k = 0; k < NGPR; k++) m_gpr[k] = '0;
        for (int k = 0; k < NOFS; k++) begin
            m_qx[k] = '0;
            m_qr[k] = '0;
        end
    endtask

    task automatic chk_ptrs(input string req);
        for (int k = 0; k < NIDX; k++) chk(req, 32'(idx_ptr_o[k*AW +: AW]), 32'(m_idx[k]));
        for (int k = 0; k < NGPR; k++) chk(req, 32'(gpr_ptr_o[k*AW +: AW]), 32'(m_gpr[k]));
    endtask

    task automatic cyc(input bit iss, input bit mv, input bit dbl,
                       input logic [0:0] isel, input logic [2:0] imode, input logic [0:0] iq,
                       input logic [3:0] gsel, input logic [2:0] gmode, input logic [0:0] gq,
                       input bit we, input bit bank, input logic [0:0] widx, input logic [15:0] wd,
                       input string tag);
        bit exp_wb;
        @(negedge clk);
        issue_i = iss; move_cls_i = mv; dbl_ind_i = dbl;
        idx_sel_i = isel; idx_mode_i = imode; idx_ofs_sel_i = iq;
        gpr_sel_i = gsel; gpr_mode_i = gmode; gpr_ofs_sel_i = gq;
        ofs_we_i = we; ofs_bank_i = bank; ofs_idx_i = widx; ofs_wdata_i = wd;
        #2;
        exp_wb = iss && mv && dbl && f_moves(imode);
        if (iss) begin
            chk({tag, " R2 idx addr"}, 32'(idx_addr_o), 32'(m_idx[isel] & 16'hFFFE));
            chk({tag, " R2 gpr addr"}, 32'(gpr_addr_o), 32'(m_gpr[gsel] & 16'hFFFE));
        end
        chk({tag, " R8 wb valid"}, 32'(wb_valid_o), 32'(exp_wb));
        chk({tag, " R10 illegal"}, 32'(illegal_o), 32'(iss && mv && dbl && !f_moves(imode)));
        if (exp_wb) chk({tag, " R9 wb addr"}, 32'(wb_addr_o), 32'(f_wb(m_idx[isel], imode, m_qx[iq])));
        @(posedge clk);
        if (iss) begin
            m_idx[isel] = f_next(m_idx[isel], imode, m_qx[iq]);
            m_gpr[gsel] = f_next(m_gpr[gsel], gmode, m_qr[gq]);
        end
        if (we) begin
            if (bank) m_qr[widx] = wd;
            else      m_qx[widx] = wd;
        end
        #2;
        chk_ptrs({tag, " R3 R6 pointers"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        issue_i = 0; move_cls_i = 0; dbl_ind_i = 0; idx_sel_i = 0; idx_mode_i = 0;
        idx_ofs_sel_i = 0; gpr_sel_i = 0; gpr_mode_i = 0; gpr_ofs_sel_i = 0;
        ofs_we_i = 0; ofs_bank_i = 0; ofs_idx_i = 0; ofs_wdata_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        #2;
        chk_ptrs("R1 reset pointers");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        rst = 1'b1;
        do_reset();

        // R1: offsets cleared, so add-offset modes leave pointers at zero
        cyc(1, 0, 1, 0, 3'd3, 0, 4'd5, 3'd4, 1, 0, 0, 0, 16'h0, "R1 offsets zero");
        // R5: wrap below zero on both families
        cyc(1, 0, 1, 0, 3'd2, 0, 4'd15, 3'd2, 0, 0, 0, 0, 16'h0, "R5 wrap dec");
        cyc(1, 0, 1, 0, 3'd1, 0, 4'd15, 3'd1, 0, 0, 0, 0, 16'h0, "R5 wrap inc");
        // R7 R4: load odd offsets, no issue; R6 pointers must hold
        cyc(0, 0, 0, 0, 3'd1, 0, 4'd0, 3'd1, 0, 1, 0, 1, 16'h0003, "R7 R6 load qx1");
        cyc(0, 0, 0, 0, 3'd1, 0, 4'd0, 3'd1, 0, 1, 1, 1, 16'h8001, "R7 R6 load qr1");
        cyc(1, 0, 0, 1, 3'd3, 1, 4'd9, 3'd4, 1, 0, 0, 0, 16'h0, "R4 odd offsets");
        // R2: odd pointers give even addresses
        cyc(1, 1, 1, 1, 3'd3, 1, 4'd9, 3'd0, 0, 0, 0, 0, 16'h0, "R2 R9 odd wb");
        // R7: write during issue is seen only afterwards
        cyc(1, 1, 1, 1, 3'd4, 1, 4'd9, 3'd3, 1, 1, 0, 1, 16'h0100, "R7 same-cycle write");
        cyc(1, 1, 1, 1, 3'd4, 1, 4'd9, 3'd0, 0, 0, 0, 0, 16'h0, "R7 after write");
        // R10: move with non-modifying modes
        cyc(1, 1, 1, 0, 3'd0, 0, 4'd2, 3'd1, 0, 0, 0, 0, 16'h0, "R10 hold mode");
        cyc(1, 1, 1, 0, 3'd6, 0, 4'd2, 3'd7, 0, 0, 0, 0, 16'h0, "R10 R3 code 6");
        // R8: move class without double indirect, and double indirect without move class
        cyc(1, 1, 0, 0, 3'd1, 0, 4'd3, 3'd1, 0, 0, 0, 0, 16'h0, "R8 no dbl");
        cyc(1, 0, 1, 0, 3'd2, 0, 4'd3, 3'd2, 0, 0, 0, 0, 16'h0, "R8 no move cls");
        cyc(1, 1, 1, 0, 3'd2, 0, 4'd3, 3'd2, 0, 0, 0, 0, 16'h0, "R9 dec inverse");

        // Random traffic
        for (int n = 0; n < 1500; n++) begin
            cyc(($urandom % 4) != 0, $urandom % 2, $urandom % 2,
                1'($urandom), 3'($urandom), 1'($urandom),
                4'($urandom), 3'($urandom), 1'($urandom),
                ($urandom % 3) == 0, $urandom % 2, 1'($urandom), 16'($urandom),
                "R3 R4 R5 R9 random");
        end

        // R1: reset in the middle of activity
        do_reset();
        cyc(1, 1, 1, 1, 3'd3, 0, 4'd7, 3'd3, 1, 0, 0, 0, 16'h0, "R1 after mid reset");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule